// File: doc/BRIEF.md
# Power-Up Operating Mode Selector

This block decides, once per reset, which operating mode a USB-to-storage bridge controller runs in and which vendor, product and device identifiers it reports to the host. It looks at three sources in a fixed order. The first is a board strap read from the drive-reset line. The second is the outcome of probing an external configuration memory. The last is the set of identity words held in one-time fuse storage. The memory probe and the fuse read are not part of this block. Each appears as a simple done/valid input together with its data.

A settle timer waits a fixed number of clock cycles after reset is released and then takes the strap level exactly once. If the strap is low, the controller goes straight into board manufacturing test mode. In that mode the storage interface stays off and the configuration memory remains reachable for reads and writes. If the strap is high, the sequencer waits for the probe result and, when needed, for the fuse words. A fuse image that is all zero means the part was never programmed. In that case the block falls back to a factory default mode with fixed identifiers.

Once a decision is made, the mode, the identifiers and a mode-valid flag are latched. They hold until the next reset.

Top module: `boot_mode_select`

## Requirements
- R1: From reset until a mode is chosen, `mode_valid_o` is 0, `mode_o` is 0 (pending), all identifier outputs are 0, and both `storage_en_o` and `cfg_access_en_o` are 0.
- R2: The strap is sampled on the SETTLE_CYCLES-th rising clock edge after reset release. If it is low there, `mode_valid_o` rises right after that same edge and `mode_o` = 2 (manufacturing test). Before that edge the selection is still pending.
- R3: A low strap overrides everything else. Even when the memory probe already reports a memory present, the mode is 2.
- R4: In mode 2, `storage_en_o` = 0 and `cfg_access_en_o` = 1. The identifiers are the defaults: vendor 0x04B4, product 0x6830, device 0x0000.
- R5: With the strap high, on the first cycle with `cfg_probe_done_i` = 1 and `cfg_present_i` = 1, the block latches mode 1 (normal) on that edge. It reports the memory's identifiers and sets `storage_en_o` = 1 and `cfg_access_en_o` = 0.
- R6: With the strap high and no memory detected, valid fuse words that are not all zero give mode 1 with the fuse identifiers.
- R7: If the three fuse words are all 0x0000, the block latches mode 3 (factory default) with vendor 0x04B4, product 0x6830 and device 0x0000. It also sets `cfg_access_en_o` = 1 and `storage_en_o` = 0.
- R8: A single nonzero fuse word, including the device word alone, is enough to count the fuses as programmed (mode 1).
- R9: After latching, the mode, the identifiers and the valid flag ignore every input change until the next reset.
- R10: The strap is read only once. If it goes low after the sample edge, the outcome does not change.
- R11: The probe result is read only once. After a probe reports no memory, the block stays pending with zero identifiers until `fuse_valid_i` arrives. A later probe claiming a memory is ignored.
- R12: When probe-done and fuse-valid arrive in the same cycle, the decision is latched on that edge. Memory presence wins over the fuses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_level_i | input | 1 | Level of the drive-reset line; low requests manufacturing test |
| cfg_probe_done_i | input | 1 | Configuration-memory probe has finished |
| cfg_present_i | input | 1 | Probe found a memory (valid with done) |
| cfg_vid_i | input | ID_W | Vendor ID read from memory |
| cfg_pid_i | input | ID_W | Product ID read from memory |
| cfg_did_i | input | ID_W | Device ID read from memory |
| fuse_valid_i | input | 1 | Fuse words are readable |
| fuse_vid_i | input | ID_W | Fused vendor ID |
| fuse_pid_i | input | ID_W | Fused product ID |
| fuse_did_i | input | ID_W | Fused device ID |
| mode_o | output | 2 | 0 pending, 1 normal, 2 manufacturing test, 3 factory default |
| mode_valid_o | output | 1 | Mode and identifiers are latched |
| vid_o | output | ID_W | Reported vendor ID |
| pid_o | output | ID_W | Reported product ID |
| did_o | output | ID_W | Reported device ID |
| storage_en_o | output | 1 | Storage interface enabled |
| cfg_access_en_o | output | 1 | Configuration memory access allowed |

## Verification
Two events can land in the same clock cycle: the probe reporting its result and the fuse words becoming valid. The bench holds both inputs low until the sequencer is waiting on the probe, then raises them together at one falling edge. It checks that the selection is still pending before the next rising edge and is latched right after it. The case is run twice. With no memory, the fuse identifiers must be chosen. With a memory present, the memory identifiers must win. A second collision is run as well: a low strap at the sample edge together with a memory already reported present. The expected result is manufacturing test.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [1:0] {
        MODE_PENDING  = 2'd0,
        MODE_NORMAL   = 2'd1,
        MODE_MFG_TEST = 2'd2,
        MODE_FACTORY  = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        SEQ_SETTLE = 2'd0,
        SEQ_PROBE  = 2'd1,
        SEQ_FUSE   = 2'd2,
        SEQ_LOCKED = 2'd3
    } seq_state_e;

    localparam int unsigned ID_WORDS = 3;
    localparam int unsigned IDX_VID  = 0;
    localparam int unsigned IDX_PID  = 1;
    localparam int unsigned IDX_DID  = 2;

endpackage

// File: rtl/bms_settle_timer.sv
module bms_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d        = q;
        sample_o = !q.done && (q.cnt == LAST);
        if (!q.done) begin
            if (sample_o) begin
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

    // R10
    sample_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> (q.done && !sample_o));

endmodule

// File: rtl/bms_fuse_blank.sv
module bms_fuse_blank #(
    parameter int unsigned ID_W      = 16,
    parameter int unsigned NUM_WORDS = 3
) (
    input  logic [NUM_WORDS-1:0][ID_W-1:0] words_i,
    output logic                           blank_o
);
    logic [NUM_WORDS-1:0] nonzero;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        assign nonzero[i] = |words_i[i];
    end

    assign blank_o = ~|nonzero;

endmodule

// File: rtl/bms_id_resolver.sv
module bms_id_resolver
    import bms_pkg::*;
#(
    parameter int unsigned ID_W    = 16,
    parameter int unsigned DEF_VID = 'h04B4,
    parameter int unsigned DEF_PID = 'h6830,
    parameter int unsigned DEF_DID = 'h0000
) (
    input  logic                          strap_low_i,
    input  logic                          cfg_present_i,
    input  logic                          fuse_blank_i,
    input  logic [ID_WORDS-1:0][ID_W-1:0] cfg_ids_i,
    input  logic [ID_WORDS-1:0][ID_W-1:0] fuse_ids_i,
    output op_mode_e                      mode_o,
    output logic [ID_WORDS-1:0][ID_W-1:0] ids_o
);
    logic [ID_WORDS-1:0][ID_W-1:0] def_ids;

    always_comb begin
        def_ids          = '0;
        def_ids[IDX_VID] = ID_W'(DEF_VID);
        def_ids[IDX_PID] = ID_W'(DEF_PID);
        def_ids[IDX_DID] = ID_W'(DEF_DID);
    end

    always_comb begin
        if (strap_low_i) begin
            mode_o = MODE_MFG_TEST;
            ids_o  = def_ids;
        end else if (cfg_present_i) begin
            mode_o = MODE_NORMAL;
            ids_o  = cfg_ids_i;
        end else if (fuse_blank_i) begin
            mode_o = MODE_FACTORY;
            ids_o  = def_ids;
        end else begin
            mode_o = MODE_NORMAL;
            ids_o  = fuse_ids_i;
        end
    end

endmodule

// File: rtl/boot_mode_select.sv
module boot_mode_select
    import bms_pkg::*;
#(
    parameter int unsigned ID_W          = 16,
    parameter int unsigned SETTLE_CYCLES = 16,
    parameter int unsigned DEF_VID       = 'h04B4,
    parameter int unsigned DEF_PID       = 'h6830,
    parameter int unsigned DEF_DID       = 'h0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_level_i,
    input  logic            cfg_probe_done_i,
    input  logic            cfg_present_i,
    input  logic [ID_W-1:0] cfg_vid_i,
    input  logic [ID_W-1:0] cfg_pid_i,
    input  logic [ID_W-1:0] cfg_did_i,
    input  logic            fuse_valid_i,
    input  logic [ID_W-1:0] fuse_vid_i,
    input  logic [ID_W-1:0] fuse_pid_i,
    input  logic [ID_W-1:0] fuse_did_i,
    output logic [1:0]      mode_o,
    output logic            mode_valid_o,
    output logic [ID_W-1:0] vid_o,
    output logic [ID_W-1:0] pid_o,
    output logic [ID_W-1:0] did_o,
    output logic            storage_en_o,
    output logic            cfg_access_en_o
);
    typedef struct packed {
        seq_state_e                    st;
        op_mode_e                      mode;
        logic                          valid;
        logic [ID_WORDS-1:0][ID_W-1:0] ids;
    } sel_t;

    sel_t q, d;

    logic                          sample;
    logic                          fuse_blank;
    logic                          lock;
    logic                          res_strap_low;
    logic                          res_cfg_present;
    op_mode_e                      res_mode;
    logic [ID_WORDS-1:0][ID_W-1:0] cfg_ids;
    logic [ID_WORDS-1:0][ID_W-1:0] fuse_ids;
    logic [ID_WORDS-1:0][ID_W-1:0] res_ids;

    always_comb begin
        cfg_ids           = '0;
        cfg_ids[IDX_VID]  = cfg_vid_i;
        cfg_ids[IDX_PID]  = cfg_pid_i;
        cfg_ids[IDX_DID]  = cfg_did_i;
        fuse_ids          = '0;
        fuse_ids[IDX_VID] = fuse_vid_i;
        fuse_ids[IDX_PID] = fuse_pid_i;
        fuse_ids[IDX_DID] = fuse_did_i;
    end

    bms_settle_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_o(sample)
    );

    bms_fuse_blank #(
        .ID_W     (ID_W),
        .NUM_WORDS(ID_WORDS)
    ) u_blank (
        .words_i(fuse_ids),
        .blank_o(fuse_blank)
    );

    bms_id_resolver #(
        .ID_W   (ID_W),
        .DEF_VID(DEF_VID),
        .DEF_PID(DEF_PID),
        .DEF_DID(DEF_DID)
    ) u_resolve (
        .strap_low_i  (res_strap_low),
        .cfg_present_i(res_cfg_present),
        .fuse_blank_i (fuse_blank),
        .cfg_ids_i    (cfg_ids),
        .fuse_ids_i   (fuse_ids),
        .mode_o       (res_mode),
        .ids_o        (res_ids)
    );

    // Decide which source is consulted this cycle and whether to lock.
    always_comb begin
        res_strap_low   = 1'b0;
        res_cfg_present = 1'b0;
        lock            = 1'b0;
        unique case (q.st)
            SEQ_SETTLE: begin
                if (sample && !strap_level_i) begin
                    res_strap_low = 1'b1;
                    lock          = 1'b1;
                end
            end
            SEQ_PROBE: begin
                if (cfg_probe_done_i) begin
                    res_cfg_present = cfg_present_i;
                    lock            = cfg_present_i || fuse_valid_i;
                end
            end
            SEQ_FUSE:   lock = fuse_valid_i;
            SEQ_LOCKED: lock = 1'b0;
            default:    lock = 1'b0;
        endcase
    end

    // Next-state computation.
    always_comb begin
        d = q;
        unique case (q.st)
            SEQ_SETTLE: if (sample && strap_level_i) d.st = SEQ_PROBE;
            SEQ_PROBE:  if (cfg_probe_done_i && !lock) d.st = SEQ_FUSE;
            default:    d.st = q.st;
        endcase
        if (lock) begin
            d.st    = SEQ_LOCKED;
            d.mode  = res_mode;
            d.valid = 1'b1;
            d.ids   = res_ids;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= SEQ_SETTLE;
            q.mode  <= MODE_PENDING;
            q.valid <= 1'b0;
            q.ids   <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode_o          = q.mode;
    assign mode_valid_o    = q.valid;
    assign vid_o           = q.ids[IDX_VID];
    assign pid_o           = q.ids[IDX_PID];
    assign did_o           = q.ids[IDX_DID];
    assign storage_en_o    = q.valid && (q.mode == MODE_NORMAL);
    assign cfg_access_en_o = q.valid &&
                             ((q.mode == MODE_MFG_TEST) || (q.mode == MODE_FACTORY));

    // R1
    pending_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid_o |-> (mode_o == 2'd0 && vid_o == '0 && pid_o == '0 &&
                           did_o == '0 && !storage_en_o && !cfg_access_en_o));

    // R2
    mfg_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_valid_o) && mode_o == 2'd2) |-> $past(sample));

    // R4
    mfg_iface_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!storage_en_o && cfg_access_en_o &&
                              vid_o == ID_W'(DEF_VID) && pid_o == ID_W'(DEF_PID)));

    // R7
    factory_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (vid_o == ID_W'(DEF_VID) && pid_o == ID_W'(DEF_PID) &&
                              did_o == ID_W'(DEF_DID)));

    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid_o |=> mode_valid_o);

    // R9
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid_o |=> ($stable(mode_o) && $stable(vid_o) &&
                          $stable(pid_o) && $stable(did_o)));

endmodule

// File: tb/tb_boot_mode_select.sv
module tb_boot_mode_select;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;
    localparam int ID_W       = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            strap = 1'b1;
    logic            cfg_done = 1'b0;
    logic            cfg_pres = 1'b0;
    logic [ID_W-1:0] cfg_vid = 16'h1234;
    logic [ID_W-1:0] cfg_pid = 16'h5678;
    logic [ID_W-1:0] cfg_did = 16'h0102;
    logic            fuse_vld = 1'b0;
    logic [ID_W-1:0] fuse_vid = 16'hABCD;
    logic [ID_W-1:0] fuse_pid = 16'h0EF0;
    logic [ID_W-1:0] fuse_did = 16'h0033;
    logic [1:0]      mode;
    logic            mvalid;
    logic [ID_W-1:0] vid, pid, did;
    logic            stor_en, cfg_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_mode_select #(
        .ID_W(ID_W),
        .SETTLE_CYCLES(SETTLE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .strap_level_i(strap),
        .cfg_probe_done_i(cfg_done), .cfg_present_i(cfg_pres),
        .cfg_vid_i(cfg_vid), .cfg_pid_i(cfg_pid), .cfg_did_i(cfg_did),
        .fuse_valid_i(fuse_vld), .fuse_vid_i(fuse_vid),
        .fuse_pid_i(fuse_pid), .fuse_did_i(fuse_did),
        .mode_o(mode), .mode_valid_o(mvalid), .vid_o(vid), .pid_o(pid),
        .did_o(did), .storage_en_o(stor_en), .cfg_access_en_o(cfg_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compares the whole output set at once.
    task automatic expect_out(input string req, input logic [1:0] m, input logic v,
                              input logic [15:0] ev, input logic [15:0] ep,
                              input logic [15:0] ed, input logic se, input logic ce);
        chk(req, {mode, mvalid, vid, pid, did, stor_en, cfg_en},
                 {m, v, ev, ep, ed, se, ce});
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic s, input logic cd, input logic cp, input logic fv);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s; cfg_done = cd; cfg_pres = cp; fuse_vld = fv;
        cfg_vid = 16'h1234; cfg_pid = 16'h5678; cfg_did = 16'h0102;
        fuse_vid = 16'hABCD; fuse_pid = 16'h0EF0; fuse_did = 16'h0033;
        edges(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R1 after release", 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        edges(SETTLE + 4);
        expect_out("R1 still pending without probe", 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic t_strap_test();
        do_reset(1'b0, 1'b1, 1'b1, 1'b1);
        edges(SETTLE - 1);
        expect_out("R2 pending before sample edge", 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        edges(1);
        expect_out("R3 R4 strap low wins", 2'd2, 1'b1, 16'h04B4, 16'h6830, 16'h0000, 1'b0, 1'b1);
    endtask

    task automatic t_cfg_normal_and_hold();
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        edges(SETTLE);
        chk("R5 not latched on sample edge", mvalid, 1'b0);
        edges(1);
        expect_out("R5 memory ids", 2'd1, 1'b1, 16'h1234, 16'h5678, 16'h0102, 1'b1, 1'b0);
        strap = 1'b0; cfg_pres = 1'b0; cfg_vid = 16'h9999; fuse_vld = 1'b1;
        fuse_vid = 16'h0; fuse_pid = 16'h0; fuse_did = 16'h0;
        edges(6);
        expect_out("R9 ignores later inputs", 2'd1, 1'b1, 16'h1234, 16'h5678, 16'h0102, 1'b1, 1'b0);
    endtask

    task automatic t_fuse_normal();
        do_reset(1'b1, 1'b1, 1'b0, 1'b1);
        edges(SETTLE + 1);
        expect_out("R6 fuse ids", 2'd1, 1'b1, 16'hABCD, 16'h0EF0, 16'h0033, 1'b1, 1'b0);
    endtask

    task automatic t_fuse_blank();
        do_reset(1'b1, 1'b1, 1'b0, 1'b1);
        fuse_vid = 16'h0; fuse_pid = 16'h0; fuse_did = 16'h0;
        edges(SETTLE + 1);
        expect_out("R7 blank fuses factory", 2'd3, 1'b1, 16'h04B4, 16'h6830, 16'h0000, 1'b0, 1'b1);
    endtask

    task automatic t_fuse_did_only();
        do_reset(1'b1, 1'b1, 1'b0, 1'b1);
        fuse_vid = 16'h0; fuse_pid = 16'h0; fuse_did = 16'h0001;
        edges(SETTLE + 1);
        expect_out("R8 device word alone programmed", 2'd1, 1'b1, 16'h0, 16'h0, 16'h0001, 1'b1, 1'b0);
    endtask

    task automatic t_strap_late();
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        edges(SETTLE + 2);
        strap = 1'b0;
        edges(3);
        chk("R10 late strap no effect", mvalid, 1'b0);
        cfg_done = 1'b1; cfg_pres = 1'b1;
        edges(1);
        expect_out("R10 normal despite late strap", 2'd1, 1'b1, 16'h1234, 16'h5678, 16'h0102, 1'b1, 1'b0);
    endtask

    task automatic t_fuse_wait();
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        edges(SETTLE + 3);
        expect_out("R11 waits for fuses", 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        cfg_pres = 1'b1;
        edges(3);
        chk("R11 late memory claim ignored", mvalid, 1'b0);
        fuse_vld = 1'b1;
        edges(1);
        expect_out("R11 fuse ids after wait", 2'd1, 1'b1, 16'hABCD, 16'h0EF0, 16'h0033, 1'b1, 1'b0);
    endtask

    task automatic t_same_cycle(input logic present);
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        edges(SETTLE + 2);
        cfg_done = 1'b1; cfg_pres = present; fuse_vld = 1'b1;
        chk("R12 pending before collision edge", mvalid, 1'b0);
        edges(1);
        if (present)
            expect_out("R12 memory beats fuses", 2'd1, 1'b1, 16'h1234, 16'h5678, 16'h0102, 1'b1, 1'b0);
        else
            expect_out("R12 fuses on same edge", 2'd1, 1'b1, 16'hABCD, 16'h0EF0, 16'h0033, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_strap_test();
        t_cfg_normal_and_hold();
        t_fuse_normal();
        t_fuse_blank();
        t_fuse_did_only();
        t_strap_late();
        t_fuse_wait();
        t_same_cycle(1'b0);
        t_same_cycle(1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule